// File: doc/BRIEF.md
# UART Receiver with Line Status

This block turns an asynchronous serial input into parallel words and keeps a status byte for the host that follows the usual 16550 conventions. A one-cycle oversample tick, sixteen per bit time, paces the receiver. After a falling edge it checks the line again at mid-bit, then samples every data, parity and stop bit in the middle of its cell. A finished word goes into a single holding register. The shared line-control field sets the word length, parity mode and parity polarity, in the same way the companion transmitter uses them.

The host pulls a word out with a data-read strobe and clears the error flags with a status-read strobe. Two transmit-side conditions come in from outside and appear in the status byte next to the receive flags. There is no FIFO and no interrupt output.

Top module: `serial_rx_status`

## Requirements
- R1: After reset `rx_word` is 0 and `line_status` bits 0 to 4 and bit 7 are 0.
- R2: `line_ctrl[1:0]` sets the word length (00=5, 01=6, 10=7, 11=8 bits). Bits arrive LSB first after the start bit. The word is delivered right-justified in `rx_word`, and status bit 0 (data ready) is set only after the stop bit has been sampled.
- R3: A `rd_data_stb` pulse clears status bit 0. `rx_word` keeps the word it holds.
- R4: When a word completes while bit 0 is still set, status bit 1 (overrun) is set. The held word is kept and the new word is discarded.
- R5: `line_ctrl[3]` enables a parity bit after the data. `line_ctrl[4]`=1 selects even parity and 0 selects odd. With `line_ctrl[5]`=1 the parity bit must be the inverse of `line_ctrl[4]`. A mismatch sets status bit 2.
- R6: A stop bit sampled as 0 sets status bit 3 (framing error).
- R7: A frame in which the start bit, every data bit, any parity bit and the stop bit are all 0 sets status bit 4 (break) together with bit 3. After any frame whose stop bit is 0, no new start bit is accepted until the line has returned to 1.
- R8: A `rd_status_stb` pulse clears status bits 1 to 4 and leaves bit 0 unchanged. A flag raised in the same cycle as the read stays set.
- R9: Status bit 7 is the OR of bits 2, 3 and 4.
- R10: Status bit 5 follows `tx_hold_empty` and bit 6 follows `tx_idle`, with no delay.
- R11: A low pulse on `rx_line` shorter than half a bit time returns the receiver to idle. No word is delivered and no flag changes.
- R12: Every bit is sampled once, at the centre of its cell. The centre is found eight ticks after the start edge and then every sixteen ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse, sixteen per bit time |
| rx_line | input | 1 | Serial input, idle high |
| line_ctrl | input | 6 | Word length [1:0], stop select [2] (not checked), parity enable [3], even [4], stick [5] |
| rd_data_stb | input | 1 | Host read of the holding register |
| rd_status_stb | input | 1 | Host read of the status byte |
| tx_hold_empty | input | 1 | Transmit holding register empty, from outside |
| tx_idle | input | 1 | Transmitter fully idle, from outside |
| rx_word | output | 8 | Held received word |
| line_status | output | 8 | Status byte |

## Verification
The assertions assume that `line_ctrl` stays constant while a frame is in flight, that `os_tick` is a single-cycle pulse, and that the read strobes last one cycle. The bench changes `line_ctrl` only while the line is idle. It drives the tick from a fixed divider, pulses each strobe for exactly one clock, and times every serial bit as sixteen ticks. This keeps the mid-bit sample well away from any edge of the line.

// File: rtl/rx_line_pkg.sv
package rx_line_pkg;
    parameter int unsigned RX_WORD_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        logic [RX_WORD_W-1:0] word;
        logic                 perr;
        logic                 ferr;
        logic                 brk;
    } rx_frame_t;
endpackage

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import rx_line_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxd,
    input  logic [5:0] lcr,
    output logic      frame_done,
    output rx_frame_t frame
);
    localparam int unsigned CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    typedef struct packed {
        rx_state_e            st;
        logic [CW-1:0]        cnt;
        logic [2:0]           idx;
        logic [RX_WORD_W-1:0] sh;
        logic                 par;
        logic                 allz;
        logic [1:0]           sync;
        logic                 done;
        rx_frame_t            frm;
    } eng_t;

    eng_t eng_d, eng_q;
    logic line;
    logic [2:0] last_idx;
    logic [2:0] shamt;
    logic exp_par;

    assign line     = eng_q.sync[1];
    assign last_idx = 3'd4 + {1'b0, lcr[1:0]};
    assign shamt    = 3'd7 - last_idx;
    assign exp_par  = lcr[5] ? ~lcr[4] : (lcr[4] ? eng_q.par : ~eng_q.par);

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        eng_d.sync = {eng_q.sync[0], rxd};
        if (tick) begin
            case (eng_q.st)
                ST_IDLE: begin
                    if (!line) begin
                        eng_d.st  = ST_START;
                        eng_d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (eng_q.cnt == MID) begin
                        eng_d.cnt = '0;
                        if (line) begin
                            eng_d.st = ST_IDLE;
                        end else begin
                            eng_d.st       = ST_DATA;
                            eng_d.idx      = '0;
                            eng_d.par      = 1'b0;
                            eng_d.allz     = 1'b1;
                            eng_d.frm.perr = 1'b0;
                        end
                    end else begin
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (eng_q.cnt == LAST) begin
                        eng_d.cnt  = '0;
                        eng_d.sh   = {line, eng_q.sh[RX_WORD_W-1:1]};
                        eng_d.par  = eng_q.par ^ line;
                        eng_d.allz = eng_q.allz & ~line;
                        if (eng_q.idx == last_idx) begin
                            eng_d.st = lcr[3] ? ST_PAR : ST_STOP;
                        end else begin
                            eng_d.idx = eng_q.idx + 1'b1;
                        end
                    end else begin
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (eng_q.cnt == LAST) begin
                        eng_d.cnt      = '0;
                        eng_d.allz     = eng_q.allz & ~line;
                        eng_d.frm.perr = (line != exp_par);
                        eng_d.st       = ST_STOP;
                    end else begin
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (eng_q.cnt == LAST) begin
                        eng_d.cnt      = '0;
                        eng_d.done     = 1'b1;
                        eng_d.frm.word = eng_q.sh >> shamt;
                        eng_d.frm.ferr = ~line;
                        eng_d.frm.brk  = eng_q.allz & ~line;
                        eng_d.st       = line ? ST_IDLE : ST_WAIT_HIGH;
                    end else begin
                        eng_d.cnt = eng_q.cnt + 1'b1;
                    end
                end
                ST_WAIT_HIGH: begin
                    if (line) eng_d.st = ST_IDLE;
                end
                default: eng_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.st   <= ST_IDLE;
            eng_q.sync <= 2'b11;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign frame_done = eng_q.done;
    assign frame      = eng_q.frm;

    // R11: a start edge that is gone at mid-bit sends the receiver back to idle
    a_r11_glitch_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && eng_q.st == ST_START && eng_q.cnt == MID && line) |=> eng_q.st == ST_IDLE);

    // R7: a break is always reported as a framing error too
    a_r7_break_has_ferr: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.done && eng_q.frm.brk) |-> eng_q.frm.ferr);

    // R7: a low stop bit holds off the next start until the line is high again
    a_r7_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_WAIT_HIGH && !line) |=> eng_q.st == ST_WAIT_HIGH);
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
    import rx_line_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_done,
    input  rx_frame_t            frame,
    input  logic                 rd_data,
    input  logic                 rd_status,
    input  logic                 tx_hold_empty,
    input  logic                 tx_idle,
    output logic [RX_WORD_W-1:0] rx_word,
    output logic [7:0]           status
);
    typedef struct packed {
        logic [RX_WORD_W-1:0] hold;
        logic dr;
        logic oe;
        logic pe;
        logic fe;
        logic bi;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_data) st_d.dr = 1'b0;
        if (rd_status) begin
            st_d.oe = 1'b0;
            st_d.pe = 1'b0;
            st_d.fe = 1'b0;
            st_d.bi = 1'b0;
        end
        if (frame_done) begin
            if (st_q.dr && !rd_data) begin
                st_d.oe = 1'b1;
            end else begin
                st_d.hold = frame.word;
                st_d.dr   = 1'b1;
                st_d.pe   = st_d.pe | frame.perr;
                st_d.fe   = st_d.fe | frame.ferr;
                st_d.bi   = st_d.bi | frame.brk;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_word = st_q.hold;
    assign status  = {st_q.pe | st_q.fe | st_q.bi, tx_idle, tx_hold_empty,
                      st_q.bi, st_q.fe, st_q.pe, st_q.oe, st_q.dr};

    a_r2_load_word: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !st_q.dr) |=> (st_q.dr && st_q.hold == $past(frame.word)));

    a_r4_keep_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && st_q.dr && !rd_data) |=> (st_q.oe && $stable(st_q.hold)));

    a_r3_dr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !frame_done) |=> !st_q.dr);

    a_r8_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !frame_done) |=> !(st_q.oe | st_q.pe | st_q.fe | st_q.bi));
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import rx_line_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_line,
    input  logic [5:0] line_ctrl,
    input  logic       rd_data_stb,
    input  logic       rd_status_stb,
    input  logic       tx_hold_empty,
    input  logic       tx_idle,
    output logic [7:0] rx_word,
    output logic [7:0] line_status
);
    logic      frame_done;
    rx_frame_t frame;

    rx_frame_engine #(.OVERSAMPLE(OVERSAMPLE)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .rxd        (rx_line),
        .lcr        (line_ctrl),
        .frame_done (frame_done),
        .frame      (frame)
    );

    rx_line_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_done    (frame_done),
        .frame         (frame),
        .rd_data       (rd_data_stb),
        .rd_status     (rd_status_stb),
        .tx_hold_empty (tx_hold_empty),
        .tx_idle       (tx_idle),
        .rx_word       (rx_word),
        .status        (line_status)
    );
endmodule

// File: tb/serial_rx_status_bench.sv
module serial_rx_status_bench;
    localparam int TDIV = 4;
    localparam int BITCLK = 16 * TDIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0;
    logic rx_line = 1'b1;
    logic [5:0] line_ctrl = 6'h03;
    logic rd_data_stb = 1'b0;
    logic rd_status_stb = 1'b0;
    logic tx_hold_empty = 1'b1;
    logic tx_idle = 1'b1;
    logic [7:0] rx_word;
    logic [7:0] line_status;

    int n_checks = 0;
    int n_errors = 0;
    int div_cnt = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (div_cnt == TDIV - 1) begin
            div_cnt = 0;
            os_tick = 1'b1;
        end else begin
            div_cnt = div_cnt + 1;
            os_tick = 1'b0;
        end
    end

    serial_rx_status u_serial_rx_status (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .line_ctrl(line_ctrl), .rd_data_stb(rd_data_stb), .rd_status_stb(rd_status_stb),
        .tx_hold_empty(tx_hold_empty), .tx_idle(tx_idle),
        .rx_word(rx_word), .line_status(line_status)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx_line = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] data, input int nbits, input bit use_par,
                        input logic parbit, input logic stopbit);
        hold_bit(1'b0);
        for (int i = 0; i < nbits; i++) hold_bit(data[i]);
        if (use_par) hold_bit(parbit);
        hold_bit(stopbit);
        rx_line = 1'b1;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic read_all();
        @(negedge clk);
        rd_data_stb = 1'b1;
        rd_status_stb = 1'b1;
        @(negedge clk);
        rd_data_stb = 1'b0;
        rd_status_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check8("R1 word after reset", rx_word, 8'h00);
        check8("R1 status after reset", line_status, 8'h60);
        tx_hold_empty = 1'b0; tx_idle = 1'b0; #1;
        check8("R10 tx bits low", line_status, 8'h00);
        tx_hold_empty = 1'b1; #1;
        check8("R10 hold empty only", line_status, 8'h20);
        tx_idle = 1'b1; #1;
        check8("R10 both high", line_status, 8'h60);
    endtask

    task automatic t_basic8();
        line_ctrl = 6'h03;
        send(8'hA5, 8, 0, 1'b0, 1'b1);
        check8("R2 R12 8-bit word", rx_word, 8'hA5);
        check8("R2 data ready", line_status, 8'h61);
        @(negedge clk); rd_data_stb = 1'b1; @(negedge clk); rd_data_stb = 1'b0; @(negedge clk);
        check8("R3 ready cleared", line_status, 8'h60);
        check8("R3 word kept", rx_word, 8'hA5);
    endtask

    task automatic t_lengths();
        line_ctrl = 6'h00; send(8'h13, 5, 0, 1'b0, 1'b1);
        check8("R2 5-bit word", rx_word, 8'h13); read_all();
        line_ctrl = 6'h01; send(8'h2A, 6, 0, 1'b0, 1'b1);
        check8("R2 6-bit word", rx_word, 8'h2A); read_all();
        line_ctrl = 6'h02; send(8'h55, 7, 0, 1'b0, 1'b1);
        check8("R2 7-bit word", rx_word, 8'h55);
        check8("R2 7-bit status", line_status, 8'h61); read_all();
    endtask

    task automatic t_parity();
        logic p;
        p = ^8'h37;
        line_ctrl = 6'h1B; send(8'h37, 8, 1, p, 1'b1);
        check8("R5 even parity good", line_status, 8'h61); read_all();
        send(8'h37, 8, 1, ~p, 1'b1);
        check8("R5 R9 even parity bad", line_status, 8'hE5);
        @(negedge clk); rd_status_stb = 1'b1; @(negedge clk); rd_status_stb = 1'b0; @(negedge clk);
        check8("R8 status read clears errors, keeps ready", line_status, 8'h61); read_all();
        line_ctrl = 6'h0B; send(8'h37, 8, 1, ~p, 1'b1);
        check8("R5 odd parity good", line_status, 8'h61); read_all();
        line_ctrl = 6'h2B; send(8'h37, 8, 1, 1'b0, 1'b1);
        check8("R5 mark parity bad", line_status, 8'hE5); read_all();
        send(8'h37, 8, 1, 1'b1, 1'b1);
        check8("R5 mark parity good", line_status, 8'h61); read_all();
        line_ctrl = 6'h3B; send(8'h37, 8, 1, 1'b0, 1'b1);
        check8("R5 space parity good", line_status, 8'h61); read_all();
        line_ctrl = 6'h03;
    endtask

    task automatic t_framing();
        send(8'h81, 8, 0, 1'b0, 1'b0);
        check8("R6 framing error", line_status, 8'hE9);
        check8("R6 word", rx_word, 8'h81); read_all();
    endtask

    task automatic t_overrun();
        send(8'h11, 8, 0, 1'b0, 1'b1);
        send(8'h22, 8, 0, 1'b0, 1'b1);
        check8("R4 held word kept", rx_word, 8'h11);
        check8("R4 overrun flag", line_status, 8'h63); read_all();
        check8("R8 overrun cleared", line_status, 8'h60);
    endtask

    task automatic t_break();
        rx_line = 1'b0;
        repeat (BITCLK * 13) @(negedge clk);
        check8("R7 break flags", line_status, 8'hF9);
        check8("R7 break word", rx_word, 8'h00);
        rx_line = 1'b1;
        repeat (BITCLK) @(negedge clk);
        read_all();
        send(8'h5A, 8, 0, 1'b0, 1'b1);
        check8("R7 word after break", rx_word, 8'h5A);
        check8("R7 status after break", line_status, 8'h61); read_all();
    endtask

    task automatic t_glitch();
        rx_line = 1'b0;
        repeat (5 * TDIV) @(negedge clk);
        rx_line = 1'b1;
        repeat (BITCLK * 12) @(negedge clk);
        check8("R11 glitch ignored", line_status, 8'h60);
        send(8'h3C, 8, 0, 1'b0, 1'b1);
        check8("R11 R12 word after glitch", rx_word, 8'h3C);
        check8("R11 status after glitch", line_status, 8'h61); read_all();
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (BITCLK) @(negedge clk);
        t_reset();
        t_basic8();
        t_lengths();
        t_parity();
        t_framing();
        t_overrun();
        t_break();
        t_glitch();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule